// File: doc/BRIEF.md
# Memory-Mapped Control and Switch Port

This block is a slave on the APB peripheral bus. It holds a small set of 32-bit control registers that the bus master can load. It also lets the master sample a matching set of single-bit switch inputs. The write side and the read side use separate maps: a write at a slot's offset loads that slot's control register, and a read at the same offset returns that slot's switch level. The control registers cannot be read back over the bus. Their contents go out as a flat vector for the logic nearby. Bit 0 of the first register also drives an LED pin.

The port sees only the low byte of the bus address. Slot `k` sits at byte offset `4*k`, and the enclosing interconnect uses the select line to pick out this block's window. With the default parameters there are two slots: control register A with switch A at offset 0x00, and control register B with switch B at offset 0x04. The port always answers at once and never signals an error.

Top module: `mmio_latch_port`

## Requirements
- R1: While the active-low reset is low, every control register holds zero, and the LED output is low.
- R2: A register takes the write data on a rising clock edge only when select, enable and write are all high. Register A (slot 0) loads when the low address byte is 0x00. Register B (slot 1) loads when it is 0x04.
- R3: An edge on which select, enable or write is low leaves every register unchanged. This covers the setup cycle of a transfer (enable low), read transfers, and stray enable or write levels while select is low.
- R4: A full write access to any offset other than 0x00 or 0x04 (for example 0x01, 0x05, 0x08 or 0xFC) changes no register.
- R5: While select is high, the read data at offset 0x00 equals switch A in bit 0, and at offset 0x04 it equals switch B in bit 0. All other bits are zero. Switch A is bit 0 of `switch_i` and switch B is bit 1. The read data follows the address and the switches combinationally, in the same cycle.
- R6: While select is high and the offset is not a slot offset, the read data is zero. While select is low, the read data is zero.
- R7: The ready output is high in every cycle after reset, so no transfer has a wait state.
- R8: The error output is low in every cycle.
- R9: The LED output always equals bit 0 of register A. Register A is bits 31:0 of `ctl_regs_o` and register B is bits 63:32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Slave select from the interconnect |
| bus_enable_i | input | 1 | High in the access cycles of a transfer |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Low byte of the bus address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_ready_o | output | 1 | Transfer completion, held high |
| bus_err_o | output | 1 | Slave error, held low |
| switch_i | input | 2 | Switch levels, one bit per slot |
| ctl_regs_o | output | 64 | Control registers, slot k at bits 32k+31:32k |
| led_o | output | 1 | Bit 0 of the slot-0 register |

## Verification
The bench first runs plain two-cycle writes to both slot offsets with distinct data patterns, so that a swapped or shared register shows. It then runs full write accesses to the near misses 0x01, 0x05, 0x08 and 0xFC, which catch decoding that ignores the low or high address bits. Setup-only cycles and stray enable or write levels with select low show whether a register loads before the access cycle or without selection. Reads are tried with all four switch combinations at both slot offsets, at offsets outside the map, and with select low, which tells a swapped mux, an unmasked upper bit and a missing select gate apart. An LFSR-driven mix of all of these then runs against the behavioural model, and it ends with a reset in the middle of the run.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

   // Byte distance between neighbouring slots in the low-address map.
   localparam int unsigned SLOT_STRIDE = 4;

   // Byte offset at which slot idx is decoded.
   function automatic int unsigned slot_offset(input int unsigned idx);
      return idx * SLOT_STRIDE;
   endfunction

   // Number of address bits needed to reach every slot.
   function automatic int unsigned map_bits(input int unsigned slots);
      return $clog2(slots * SLOT_STRIDE);
   endfunction

endpackage

// File: rtl/mmio_slot_decode.sv
module mmio_slot_decode #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_SLOTS = 2
) (
   input  logic                 sel_i,
   input  logic                 enable_i,
   input  logic                 write_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [NUM_SLOTS-1:0] hit_o,
   output logic [NUM_SLOTS-1:0] wr_stb_o
);
   import mmio_pkg::*;

   localparam int unsigned NEED_W = map_bits(NUM_SLOTS);

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("mmio_slot_decode: NUM_SLOTS must be at least 1");
   end
   if (NEED_W > ADDR_W) begin : g_bad_width
      $error("mmio_slot_decode: ADDR_W too narrow for NUM_SLOTS");
   end

   // The access cycle is the only one that may commit a write.
   logic access_wr;
   assign access_wr = sel_i & enable_i & write_i;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(slot_offset(s));
      // Full compare of every visible address bit: aliases are misses.
      assign hit_o[s]    = (addr_i == OFFS);
      assign wr_stb_o[s] = access_wr & hit_o[s];
   end

endmodule

// File: rtl/mmio_ctl_bank.sv
module mmio_ctl_bank #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_SLOTS = 2
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_SLOTS-1:0]        wr_stb_i,
   input  logic [DATA_W-1:0]           wdata_i,
   output logic [NUM_SLOTS*DATA_W-1:0] regs_o
);

   if (DATA_W < 1) begin : g_bad_data
      $error("mmio_ctl_bank: DATA_W must be at least 1");
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_reg
      logic [DATA_W-1:0] q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            q <= '0;
         end else if (wr_stb_i[s]) begin
            q <= wdata_i;
         end
      end

      assign regs_o[s*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/mmio_sw_readmux.sv
module mmio_sw_readmux #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_SLOTS = 2
) (
   input  logic                 sel_i,
   input  logic [NUM_SLOTS-1:0] hit_i,
   input  logic [NUM_SLOTS-1:0] sw_i,
   output logic [DATA_W-1:0]    rdata_o
);

   logic sw_pick;

   // At most one hit is set, so an OR over masked switches is a mux.
   always_comb begin
      sw_pick = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         sw_pick = sw_pick | (hit_i[s] & sw_i[s]);
      end
   end

   assign rdata_o = sel_i ? DATA_W'(sw_pick) : '0;

endmodule

// File: rtl/mmio_latch_port.sv
module mmio_latch_port #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_SLOTS = 2,
   parameter int unsigned LED_SLOT  = 0
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        bus_sel_i,
   input  logic                        bus_enable_i,
   input  logic                        bus_write_i,
   input  logic [ADDR_W-1:0]           bus_addr_i,
   input  logic [DATA_W-1:0]           bus_wdata_i,
   output logic [DATA_W-1:0]           bus_rdata_o,
   output logic                        bus_ready_o,
   output logic                        bus_err_o,
   input  logic [NUM_SLOTS-1:0]        switch_i,
   output logic [NUM_SLOTS*DATA_W-1:0] ctl_regs_o,
   output logic                        led_o
);

   if (LED_SLOT >= NUM_SLOTS) begin : g_bad_led
      $error("mmio_latch_port: LED_SLOT outside the slot range");
   end

   logic [NUM_SLOTS-1:0] hit;
   logic [NUM_SLOTS-1:0] wr_stb;

   mmio_slot_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_decode (
      .sel_i    (bus_sel_i),
      .enable_i (bus_enable_i),
      .write_i  (bus_write_i),
      .addr_i   (bus_addr_i),
      .hit_o    (hit),
      .wr_stb_o (wr_stb)
   );

   mmio_ctl_bank #(
      .DATA_W    (DATA_W),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_stb_i (wr_stb),
      .wdata_i  (bus_wdata_i),
      .regs_o   (ctl_regs_o)
   );

   mmio_sw_readmux #(
      .DATA_W    (DATA_W),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_rmux (
      .sel_i   (bus_sel_i),
      .hit_i   (hit),
      .sw_i    (switch_i),
      .rdata_o (bus_rdata_o)
   );

   // Zero-wait, error-free slave.
   assign bus_ready_o = 1'b1;
   assign bus_err_o   = 1'b0;
   assign led_o       = ctl_regs_o[LED_SLOT*DATA_W];

endmodule

// File: rtl/mmio_latch_port_chk.sv
module mmio_latch_port_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_SLOTS = 2
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        bus_sel_i,
   input logic                        bus_enable_i,
   input logic                        bus_write_i,
   input logic [ADDR_W-1:0]           bus_addr_i,
   input logic [DATA_W-1:0]           bus_wdata_i,
   input logic [DATA_W-1:0]           bus_rdata_o,
   input logic                        bus_ready_o,
   input logic                        bus_err_o,
   input logic [NUM_SLOTS-1:0]        switch_i,
   input logic [NUM_SLOTS*DATA_W-1:0] ctl_regs_o,
   input logic                        led_o
);

   // Outside the map: misaligned, or beyond the last slot.
   logic off_map;
   assign off_map = (bus_addr_i[1:0] != 2'b00) ||
                    (int'(bus_addr_i) >= int'(NUM_SLOTS * 4));

   // R1: registers are cleared while reset is held
   a_r1_reset_clear: assert property (@(posedge clk_i)
      !rst_ni |-> (ctl_regs_o == '0));

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      // R2: access-cycle write at the slot offset loads that slot
      a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (bus_sel_i && bus_enable_i && bus_write_i && (int'(bus_addr_i) == s*4))
         |=> (ctl_regs_o[s*DATA_W +: DATA_W] == $past(bus_wdata_i)));

      // R5: selected read at the slot offset returns the switch
      a_r5_switch_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (bus_sel_i && (int'(bus_addr_i) == s*4))
         |-> (bus_rdata_o == DATA_W'(switch_i[s])));
   end

   // R3: no write without select, enable and write all high
   a_r3_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_sel_i && bus_enable_i && bus_write_i) |=> $stable(ctl_regs_o));

   // R4: writes outside the map are dropped
   a_r4_offmap_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && bus_enable_i && bus_write_i && off_map) |=> $stable(ctl_regs_o));

   // R6: off-map or unselected reads return zero
   a_r6_offmap_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && off_map) |-> (bus_rdata_o == '0));
   a_r6_unselected_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_sel_i |-> (bus_rdata_o == '0));

   // R7: never stalls
   a_r7_ready_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_ready_o);

   // R8: never errors
   a_r8_no_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_err_o);

   // R9: LED mirrors bit 0 of slot 0
   a_r9_led_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      led_o == ctl_regs_o[0]);

endmodule

bind mmio_latch_port mmio_latch_port_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NUM_SLOTS (NUM_SLOTS)
) u_chk (.*);

// File: tb/mmio_latch_port_bench.sv
module mmio_latch_port_bench;

   localparam int DW = 32;
   localparam int AW = 8;
   localparam int NS = 2;

   logic            clk_i = 1'b0;
   logic            rst_ni = 1'b0;
   logic            bus_sel_i = 1'b0;
   logic            bus_enable_i = 1'b0;
   logic            bus_write_i = 1'b0;
   logic [AW-1:0]   bus_addr_i = '0;
   logic [DW-1:0]   bus_wdata_i = '0;
   logic [DW-1:0]   bus_rdata_o;
   logic            bus_ready_o;
   logic            bus_err_o;
   logic [NS-1:0]   switch_i = '0;
   logic [NS*DW-1:0] ctl_regs_o;
   logic            led_o;

   mmio_latch_port u_mmio_latch_port (.*);

   always #10 clk_i = ~clk_i;   // 50 MHz

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // Behavioural model: registers keyed by their byte offset.
   logic [DW-1:0] model_q[int];

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_rdata();
      if (!bus_sel_i) return '0;
      case (int'(bus_addr_i))
         0:       return DW'(switch_i[0]);
         4:       return DW'(switch_i[1]);
         default: return '0;
      endcase
   endfunction

   initial begin
      model_q[0] = '0;
      model_q[4] = '0;
   end

   always @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         model_q[0] = '0;
         model_q[4] = '0;
      end else if (bus_sel_i && bus_enable_i && bus_write_i) begin
         if (bus_addr_i == 8'h00) model_q[0] = bus_wdata_i;
         else if (bus_addr_i == 8'h04) model_q[4] = bus_wdata_i;
      end
   end

   // Compare on every falling edge, halfway between driver updates.
   always @(negedge clk_i) begin
      if (!done) begin
         check("R2/R3/R4 reg A", ctl_regs_o[DW-1:0], model_q[0]);
         check("R2/R3/R4 reg B", ctl_regs_o[2*DW-1:DW], model_q[4]);
         check("R9 led", DW'(led_o), DW'(model_q[0][0]));
         check("R5/R6 rdata", bus_rdata_o, exp_rdata());
         if (rst_ni) begin
            check("R7 ready", DW'(bus_ready_o), 32'd1);
         end
         check("R8 err", DW'(bus_err_o), 32'd0);
      end
   end

   task automatic step();
      @(posedge clk_i);
      #4;
   endtask

   task automatic idle();
      bus_sel_i = 1'b0; bus_enable_i = 1'b0; bus_write_i = 1'b0;
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_sel_i = 1'b1; bus_enable_i = 1'b0; bus_write_i = 1'b1;
      bus_addr_i = a; bus_wdata_i = d;
      step();
      bus_enable_i = 1'b1;
      step();
      idle();
   endtask

   task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      bus_sel_i = 1'b1; bus_enable_i = 1'b0; bus_write_i = 1'b0; bus_addr_i = a;
      #2 check(tag, bus_rdata_o, exp);
      step();
      bus_enable_i = 1'b1;
      #2 check(tag, bus_rdata_o, exp);
      step();
      idle();
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      step(); step(); step();
      // R1: registers zero and LED low under reset
      check("R1 reg A in reset", ctl_regs_o[DW-1:0], '0);
      check("R1 reg B in reset", ctl_regs_o[2*DW-1:DW], '0);
      check("R1 led in reset", DW'(led_o), '0);
      rst_ni = 1'b1;
      step();

      // R2: both slots with distinct patterns
      bus_write(8'h00, 32'h1234_5671);
      check("R2 reg A load", ctl_regs_o[DW-1:0], 32'h1234_5671);
      check("R9 led high", DW'(led_o), 32'd1);
      bus_write(8'h04, 32'hA5A5_0000);
      check("R2 reg B load", ctl_regs_o[2*DW-1:DW], 32'hA5A5_0000);
      check("R2 reg A untouched", ctl_regs_o[DW-1:0], 32'h1234_5671);

      // R4: near-miss offsets change nothing
      bus_write(8'h01, 32'hFFFF_FFFF);
      bus_write(8'h05, 32'hFFFF_FFFF);
      bus_write(8'h08, 32'hFFFF_FFFF);
      bus_write(8'hFC, 32'hFFFF_FFFF);
      check("R4 reg A kept", ctl_regs_o[DW-1:0], 32'h1234_5671);
      check("R4 reg B kept", ctl_regs_o[2*DW-1:DW], 32'hA5A5_0000);

      // R3: setup cycle only, then abort
      bus_sel_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = 8'h00; bus_wdata_i = 32'h0;
      step();
      idle();
      check("R3 setup-only no write", ctl_regs_o[DW-1:0], 32'h1234_5671);
      // R3: enable and write without select
      bus_enable_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = 8'h04; bus_wdata_i = 32'h0;
      step(); step();
      idle();
      check("R3 unselected no write", ctl_regs_o[2*DW-1:DW], 32'hA5A5_0000);
      // R3: read access does not load
      bus_read(8'h00, DW'(switch_i[0]), "R3/R5 read access");
      check("R3 read no write", ctl_regs_o[DW-1:0], 32'h1234_5671);

      // R5 / R6: all switch combinations
      for (int c = 0; c < 4; c++) begin
         switch_i = NS'(c);
         bus_read(8'h00, DW'(c & 1), "R5 switch A");
         bus_read(8'h04, DW'((c >> 1) & 1), "R5 switch B");
         bus_read(8'h08, '0, "R6 off-map read");
         bus_read(8'h01, '0, "R6 misaligned read");
         #2 check("R6 unselected read", bus_rdata_o, '0);
      end

      // R9: LED drops when bit 0 clears
      bus_write(8'h00, 32'hFFFF_FFFE);
      check("R9 led low", DW'(led_o), 32'd0);

      // Mixed traffic against the model
      for (int i = 0; i < 200; i++) begin
         logic [AW-1:0] a;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         switch_i = lfsr[9:8];
         case (lfsr[2:0])
            3'd0, 3'd1: a = 8'h00;
            3'd2, 3'd3: a = 8'h04;
            3'd4:       a = 8'h08;
            3'd5:       a = 8'h03;
            default:    a = AW'(lfsr[15:8]);
         endcase
         if (lfsr[3]) bus_write(a, {lfsr, ~lfsr});
         else         bus_read(a, exp_rdata_for(a), "R5/R6 mixed read");
      end

      // R1: reset in mid-run clears state
      bus_write(8'h00, 32'h0000_0003);
      rst_ni = 1'b0;
      #2;
      check("R1 reg A mid reset", ctl_regs_o[DW-1:0], '0);
      check("R1 reg B mid reset", ctl_regs_o[2*DW-1:DW], '0);
      step();
      rst_ni = 1'b1;
      step();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   function automatic logic [DW-1:0] exp_rdata_for(input logic [AW-1:0] a);
      if (a == 8'h00) return DW'(switch_i[0]);
      if (a == 8'h04) return DW'(switch_i[1]);
      return '0;
   endfunction

endmodule